// File: doc/BRIEF.md
# Erase-Block Write Guard

This block holds the write-protection state of a flash array split into 135 erase blocks and judges every program or erase request against it. Each block carries a volatile protect bit and a volatile freeze bit. While the active-low write-protect pin is held low, the freeze bit stops the protect bit from changing. A small one-time lock register sits above all of this. One of its bits makes a chosen security block unwritable for good. Another makes the user half of a 128-bit protection register unwritable. The lower half of that register is a fixed device identifier and is never writable.

The command engine presents one command per cycle with a block index and, when needed, an argument. The guard answers program, erase and protection-register writes with a one-cycle permit or deny pulse in the next cycle. A denial also sets a sticky error flag. A query port reports the effective protect and freeze state of any block combinationally. Address-to-block decoding happens upstream.

Top module: `blk_guard`

## Requirements
- R1: After power-on reset (`por_n` low), every block reads protected and not frozen, `lock_reg` is 000, and `prot_err`, `op_ok` and `op_deny` are 0.
- R2: A reset pulse on `rst_n` returns every block to protected and not frozen and clears `prot_err`. `lock_reg` keeps its value.
- R3: Command codes: 3 sets the protect bit of block `cmd_blk` and 4 clears it. No other block is affected. An index of 135 or more has no effect. Querying an index of 135 or more reads protected and not frozen.
- R4: Code 5 sets the freeze bit of `cmd_blk`. Only a reset clears it. While `wp_n` is 0, codes 3 and 4 have no effect on a frozen block. While `wp_n` is 1, they apply.
- R5: Codes 1 (program) and 2 (erase) give `op_ok` one cycle after the command when the block index is in range and the block is not protected. Otherwise they give `op_deny`. Each is a single-cycle pulse, and the two are never both high.
- R6: Every denial sets `prot_err`. It stays set until code 6 clears it.
- R7: Code 8 ORs `cmd_arg` into `lock_reg`. Lock-register bits never go from 1 to 0 except at power-on.
- R8: While `lock_reg[2]` is 1, block 0 reads protected and its program and erase requests are denied, whatever its protect bit holds.
- R9: Code 7 (protection-register write) selects the segment with `cmd_blk[0]`. Segment 0, the identifier, is always denied. Segment 1 is denied when `lock_reg[1]` is 1 and permitted otherwise.
- R10: Codes 0 and 9 to 15 change no state and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state including the lock register |
| rst_n | input | 1 | Reset/power-down exit, active low, clears volatile state only |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 4 | Command code |
| cmd_blk | input | 8 | Target block index, or segment select for code 7 |
| cmd_arg | input | 3 | Bits to set in the lock register for code 8 |
| wp_n | input | 1 | Write-protect pin, low enforces the freeze bits |
| q_blk | input | 8 | Block index to query |
| q_prot | output | 1 | Effective protection of the queried block |
| q_lock | output | 1 | Freeze bit of the queried block |
| lock_reg | output | 3 | One-time lock register |
| op_ok | output | 1 | Request permitted (pulse) |
| op_deny | output | 1 | Request denied (pulse) |
| prot_err | output | 1 | Sticky protection error |

## Verification
The hardest state to reach is a frozen block under a low write-protect pin. To get there, the bench unprotects a block, freezes it, and then issues protect and unprotect commands with the pin both low and high. The query port shows which changes took hold. The security-block override is also awkward to reach. The bench unprotects block 0, burns the lock bit, and then shows that program requests are refused. It then shows that this refusal survives an ordinary reset and ends only at power-on.

// File: rtl/blk_guard.sv
module blk_guard #(
  parameter int NUM_BLOCKS = 135,
  parameter int IDX_W      = 8,
  parameter int SEC_BLOCK  = 0,
  parameter int LR_W       = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic [IDX_W-1:0] cmd_blk,
  input  logic [LR_W-1:0]  cmd_arg,
  input  logic             wp_n,
  input  logic [IDX_W-1:0] q_blk,
  output logic             q_prot,
  output logic             q_lock,
  output logic [LR_W-1:0]  lock_reg,
  output logic             op_ok,
  output logic             op_deny,
  output logic             prot_err
);

  localparam logic [3:0] C_PROG   = 4'd1;
  localparam logic [3:0] C_ERASE  = 4'd2;
  localparam logic [3:0] C_PROT   = 4'd3;
  localparam logic [3:0] C_UNPROT = 4'd4;
  localparam logic [3:0] C_LOCK   = 4'd5;
  localparam logic [3:0] C_CLR    = 4'd6;
  localparam logic [3:0] C_PREG   = 4'd7;
  localparam logic [3:0] C_LRPROG = 4'd8;
  localparam int         LR_USER  = 1;
  localparam int         LR_SEC   = 2;

  logic                  vrst_n;
  logic [NUM_BLOCKS-1:0] prot_r, lock_r, sec_mask, eff_prot;
  logic [LR_W-1:0]       lr_r;
  logic                  in_rng, q_rng, tgt_prot, frozen;
  logic                  is_pe, is_preg, deny, allow;

  assign vrst_n   = rst_n & por_n;
  assign sec_mask = lr_r[LR_SEC] ? (NUM_BLOCKS'(1) << SEC_BLOCK) : '0;
  assign eff_prot = prot_r | sec_mask;

  assign in_rng   = cmd_blk < IDX_W'(NUM_BLOCKS);
  assign q_rng    = q_blk < IDX_W'(NUM_BLOCKS);
  assign tgt_prot = in_rng ? eff_prot[cmd_blk] : 1'b1;
  assign frozen   = in_rng & lock_r[cmd_blk] & ~wp_n;

  assign is_pe    = cmd_valid & ((cmd_code == C_PROG) | (cmd_code == C_ERASE));
  assign is_preg  = cmd_valid & (cmd_code == C_PREG);
  assign deny     = (is_pe & tgt_prot) | (is_preg & (~cmd_blk[0] | lr_r[LR_USER]));
  assign allow    = (is_pe | is_preg) & ~deny;

  assign q_prot   = q_rng ? eff_prot[q_blk] : 1'b1;
  assign q_lock   = q_rng ? lock_r[q_blk] : 1'b0;
  assign lock_reg = lr_r;

  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n) begin
      prot_r   <= '1;
      lock_r   <= '0;
      op_ok    <= 1'b0;
      op_deny  <= 1'b0;
      prot_err <= 1'b0;
    end else begin
      op_ok   <= allow;
      op_deny <= deny;
      if (deny)
        prot_err <= 1'b1;
      else if (cmd_valid && cmd_code == C_CLR)
        prot_err <= 1'b0;
      if (cmd_valid && in_rng && !frozen) begin
        case (cmd_code)
          C_PROT:   prot_r[cmd_blk] <= 1'b1;
          C_UNPROT: prot_r[cmd_blk] <= 1'b0;
          default:  ;
        endcase
      end
      if (cmd_valid && in_rng && cmd_code == C_LOCK)
        lock_r[cmd_blk] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      lr_r <= '0;
    else if (cmd_valid && cmd_code == C_LRPROG)
      lr_r <= lr_r | cmd_arg;
  end

  AST_OK_DENY_EXCL: assert property (@(posedge clk) disable iff (!vrst_n) !(op_ok && op_deny)); // R5
  AST_PE_DENIED: assert property (@(posedge clk) disable iff (!vrst_n)
    (is_pe && tgt_prot) |=> (op_deny && !op_ok)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!vrst_n)
    (prot_err && !(cmd_valid && cmd_code == C_CLR)) |=> prot_err); // R6
  AST_DENY_SETS_ERR: assert property (@(posedge clk) disable iff (!vrst_n) op_deny |-> prot_err); // R6
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!vrst_n)
    (cmd_valid && (cmd_code == C_PROT || cmd_code == C_UNPROT) && in_rng && lock_r[cmd_blk] && !wp_n)
    |=> $stable(prot_r)); // R4
  AST_LR_NO_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> ((lr_r & $past(lr_r)) == $past(lr_r))); // R7
  AST_SEC_DENIED: assert property (@(posedge clk) disable iff (!vrst_n)
    (is_pe && lr_r[LR_SEC] && cmd_blk == IDX_W'(SEC_BLOCK)) |=> op_deny); // R8
  AST_ID_SEG_DENIED: assert property (@(posedge clk) disable iff (!vrst_n)
    (is_preg && !cmd_blk[0]) |=> op_deny); // R9

endmodule

// File: tb/blk_guard_tb_top.sv
`timescale 1ns/1ps
module blk_guard_tb_top;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [7:0] cmd_blk = '0, q_blk = '0;
  logic [2:0] cmd_arg = '0;
  logic       wp_n = 1'b1;
  logic       q_prot, q_lock, op_ok, op_deny, prot_err;
  logic [2:0] lock_reg;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  blk_guard dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_blk(cmd_blk), .cmd_arg(cmd_arg), .wp_n(wp_n),
    .q_blk(q_blk), .q_prot(q_prot), .q_lock(q_lock), .lock_reg(lock_reg),
    .op_ok(op_ok), .op_deny(op_deny), .prot_err(prot_err)
  );

  // {req4, cmd4, blk8, arg3, wp1, qblk8, ok, deny, err, qprot, qlock}
  localparam int NV = 29;
  localparam logic [32:0] VEC [NV] = '{
    {4'd5, 4'd1, 8'd5,   3'd0, 1'b1, 8'd5,   5'b01110}, // R5 program protected
    {4'd6, 4'd6, 8'd0,   3'd0, 1'b1, 8'd5,   5'b00010}, // R6 clear
    {4'd3, 4'd4, 8'd5,   3'd0, 1'b1, 8'd5,   5'b00000}, // R3 unprotect
    {4'd5, 4'd1, 8'd5,   3'd0, 1'b1, 8'd5,   5'b10000}, // R5 program ok
    {4'd5, 4'd2, 8'd5,   3'd0, 1'b1, 8'd5,   5'b10000}, // R5 erase ok
    {4'd4, 4'd5, 8'd5,   3'd0, 1'b1, 8'd5,   5'b00001}, // R4 freeze
    {4'd4, 4'd3, 8'd5,   3'd0, 1'b0, 8'd5,   5'b00001}, // R4 frozen protect ignored
    {4'd4, 4'd3, 8'd5,   3'd0, 1'b1, 8'd5,   5'b00011}, // R4 pin high applies
    {4'd4, 4'd4, 8'd5,   3'd0, 1'b0, 8'd5,   5'b00011}, // R4 frozen unprotect ignored
    {4'd3, 4'd4, 8'd134, 3'd0, 1'b0, 8'd134, 5'b00000}, // R3 last block, unfrozen
    {4'd5, 4'd2, 8'd134, 3'd0, 1'b1, 8'd134, 5'b10000}, // R5
    {4'd3, 4'd4, 8'd135, 3'd0, 1'b1, 8'd135, 5'b00010}, // R3 out of range
    {4'd5, 4'd2, 8'd135, 3'd0, 1'b1, 8'd135, 5'b01110}, // R5 out of range denied
    {4'd6, 4'd6, 8'd0,   3'd0, 1'b1, 8'd134, 5'b00000}, // R6
    {4'd9, 4'd7, 8'd0,   3'd0, 1'b1, 8'd0,   5'b01110}, // R9 id segment
    {4'd6, 4'd6, 8'd0,   3'd0, 1'b1, 8'd0,   5'b00010}, // R6
    {4'd9, 4'd7, 8'd1,   3'd0, 1'b1, 8'd0,   5'b10010}, // R9 user segment ok
    {4'd3, 4'd4, 8'd0,   3'd0, 1'b1, 8'd0,   5'b00000}, // R3
    {4'd5, 4'd1, 8'd0,   3'd0, 1'b1, 8'd0,   5'b10000}, // R5
    {4'd8, 4'd8, 8'd0,   3'd4, 1'b1, 8'd0,   5'b00010}, // R8 burn security bit
    {4'd8, 4'd1, 8'd0,   3'd0, 1'b1, 8'd0,   5'b01110}, // R8 denied
    {4'd8, 4'd4, 8'd0,   3'd0, 1'b1, 8'd0,   5'b00110}, // R8 still protected
    {4'd6, 4'd6, 8'd0,   3'd0, 1'b1, 8'd0,   5'b00010}, // R6
    {4'd7, 4'd8, 8'd0,   3'd2, 1'b1, 8'd0,   5'b00010}, // R7 burn user bit
    {4'd9, 4'd7, 8'd1,   3'd0, 1'b1, 8'd0,   5'b01110}, // R9 user segment locked
    {4'd6, 4'd6, 8'd0,   3'd0, 1'b1, 8'd0,   5'b00010}, // R6
    {4'd10,4'd15,8'd5,   3'd0, 1'b1, 8'd5,   5'b00011}, // R10 unused code
    {4'd4, 4'd5, 8'd134, 3'd0, 1'b1, 8'd134, 5'b00001}, // R4
    {4'd4, 4'd3, 8'd134, 3'd0, 1'b1, 8'd134, 5'b00011}  // R4
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] c, input logic [7:0] b, input logic [2:0] a,
                     input logic w, input logic [7:0] qb);
    cmd_valid = 1'b1; cmd_code = c; cmd_blk = b; cmd_arg = a; wp_n = w; q_blk = qb;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [4:0] got;
    int bad;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R1 power-on state, every block
    bad = 0;
    for (int i = 0; i < 135; i++) begin
      q_blk = 8'(i); #1;
      if (q_prot !== 1'b1 || q_lock !== 1'b0) bad++;
    end
    chk("R1 blocks protected/unfrozen", 8'(bad), 8'd0);
    chk("R1 lock_reg/err/pulses", {3'b0, lock_reg, prot_err, op_ok}, 8'd0);
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      cmd(VEC[v][28:25], VEC[v][24:17], VEC[v][16:14], VEC[v][13], VEC[v][12:5]);
      got = {op_ok, op_deny, prot_err, q_prot, q_lock};
      checks++;
      if (got !== VEC[v][4:0]) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%b expected=%b", VEC[v][32:29], v, got, VEC[v][4:0]);
      end
    end
    // R5 pulse lasts one cycle
    cmd(4'd0, 8'd0, 3'd0, 1'b1, 8'd134);
    chk("R5 pulse width", {6'b0, op_ok, op_deny}, 8'd0);
    chk("R7 lock_reg value", {5'b0, lock_reg}, 8'd6);
    cmd(4'd8, 8'd0, 3'd0, 1'b1, 8'd0);
    chk("R7 no clear", {5'b0, lock_reg}, 8'd6);
    // R2 reset keeps lock register
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R2 lock_reg kept", {5'b0, lock_reg}, 8'd6);
    chk("R2 err cleared", {7'b0, prot_err}, 8'd0);
    q_blk = 8'd134; #1;
    chk("R2 block 134 restored", {6'b0, q_prot, q_lock}, 8'b10);
    q_blk = 8'd5; #1;
    chk("R2 block 5 restored", {6'b0, q_prot, q_lock}, 8'b10);
    cmd(4'd4, 8'd0, 3'd0, 1'b1, 8'd0);
    cmd(4'd1, 8'd0, 3'd0, 1'b1, 8'd0);
    chk("R8 after reset", {6'b0, op_ok, op_deny}, 8'b01);
    // power-on clears lock register
    por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
    chk("R1 lock_reg cleared", {5'b0, lock_reg}, 8'd0);
    cmd(4'd4, 8'd0, 3'd0, 1'b1, 8'd0);
    cmd(4'd1, 8'd0, 3'd0, 1'b1, 8'd0);
    chk("R8 released by power-on", {6'b0, op_ok, op_deny}, 8'b10);
    finish_run();
  end
endmodule